// File: doc/BRIEF.md
# Streaming Largest/Smallest Subset Extractor

This block watches a long stream of unsigned items and keeps two sorted subsets of it: the `TOP_N` largest items admitted so far and the `BOT_N` smallest. Items arrive on a valid/ready stream and are grouped into chunks of `CHUNK_K` arrivals. A chunk closes when its `CHUNK_K`-th item is accepted or when an item carrying the last flag is accepted. Each chunk is written into the middle part of one register network of `TOP_N + CHUNK_K + BOT_N` slots. The upper part of that network keeps the retained largest items and the lower part keeps the retained smallest ones. After each chunk the network runs an iterative odd/even transposition sort. Each clock cycle is one phase of compare-exchange steps on adjacent slots.

For the first chunk of a stream, the two comparators that join the middle part to the upper and lower parts are switched off, and the sorted chunk is then copied outward. For every later chunk all comparators run over the whole network. A sort ends as soon as two consecutive phases make no exchange. A one-cycle realignment then refreshes the lower part and empties the middle part. An optional range filter checks each arriving item against two bounds and drops the items that fall outside them. A dropped item still counts as an arrival of its chunk. Slots that stay empty carry a per-slot invalid flag.

When the chunk holding the last item has been sorted, `done` rises and the two subsets can be read from the outputs. They stay there until reset.

Top module: `subsetExtract`

## Requirements
- R1: After reset, `done` is 0, every bit of `topValid` and `botValid` is 0, and `inReady` is 1.
- R2: A chunk is `CHUNK_K` accepted arrivals, admitted or dropped, or fewer when an arrival has `inLast`=1. `inReady` is 0 from the cycle after the chunk's closing item is accepted until the sort and realignment of that chunk are over.
- R3: Once `done` is 1, top slot i (bits i*DATA_W upward) holds the (i+1)-th largest admitted item, counting duplicates, so the slots run in descending order. `topValid[i]` is 0 when fewer than i+1 items were admitted.
- R4: Let v be the number of admitted items and s their descending list (index 0 is the largest). Let start = max(v-BOT_N, TOP_N). Once `done` is 1, bottom slot j holds s[start+j] with `botValid[j]`=1 when start+j < v, and has `botValid[j]`=0 otherwise. The bottom slots therefore hold the smallest admitted items that are not in the top subset, in descending order.
- R5: `filterMode` 0 or 3 admits every item. Mode 1 admits D only when boundLo ≤ D ≤ boundHi. Mode 2 admits D only when boundLo < D < boundHi. All comparisons are unsigned.
- R6: A dropped item never appears in either subset. An invalid slot never takes the place of an admitted item. A sort phase never changes the number of valid slots.
- R7: During the sort of a stream's first chunk, the upper and lower parts do not change. After that sort the chunk's largest items sit in the upper part. Streams of several chunks give the same subsets as R3/R4.
- R8: A sort ends after the first pair of consecutive phases that both make no exchange, and takes at most TOP_N+CHUNK_K+BOT_N+2 phases. For an already descending first chunk, `inReady` stays 0 for exactly 3 cycles: two quiet phases and one realignment cycle.
- R9: Once `done` is 1 it stays 1 and `inReady` stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Item offered |
| inReady | output | 1 | Block can accept an item |
| inData | input | DATA_W | Item value, unsigned |
| inLast | input | 1 | Item is the last of the stream |
| boundLo | input | DATA_W | Lower filter bound |
| boundHi | input | DATA_W | Upper filter bound |
| filterMode | input | 2 | 0/3 off, 1 inclusive range, 2 strict range |
| topData | output | TOP_N*DATA_W | Largest items, slot 0 in the low bits |
| topValid | output | TOP_N | Per-slot valid flag of the top subset |
| botData | output | BOT_N*DATA_W | Smallest items not in the top subset, slot 0 in the low bits |
| botValid | output | BOT_N | Per-slot valid flag of the bottom subset |
| done | output | 1 | Last chunk sorted, subsets final |

## Verification
Some faults never reach the ports, such as a lost swap or a comparator link that stays enabled on the first chunk. Those are caught inside the network when they happen: by the check that the count of valid slots stays the same, by the checks on the order of the upper and lower parts the cycle after realignment, and by the check that the outer parts stay still during the first sort. A wrong early stop shows at the ports as an `inReady` low time that differs from the expected three cycles for a descending chunk, or as a wrong order in the subsets. A slip in the filter or in the window arithmetic shows in the top or bottom slots and their valid flags as soon as `done` rises, at the end of the stream.

// File: rtl/subset_pkg.sv
package subset_pkg;

  // Range filter selection on the filterMode port
  typedef enum logic [1:0] {
    FILT_OFF    = 2'd0,
    FILT_INCL   = 2'd1,
    FILT_STRICT = 2'd2,
    FILT_ANY    = 2'd3
  } filtMode_e;

  // Controller states
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_SORT  = 2'd1,
    ST_ALIGN = 2'd2,
    ST_FIN   = 2'd3
  } ctrlState_e;

  // Strobes from the controller to the slot network
  typedef struct packed {
    logic loadWr;      // write an admitted item into the next middle slot
    logic sortEn;      // run one compare-exchange phase
    logic oddPhase;    // 0: pairs starting on even slots, 1: on odd slots
    logic firstChunk;  // cut the links around the middle part
    logic realign;     // refresh the outer parts and empty the middle
  } netCtrl_t;

endpackage

// File: rtl/subsetFilter.sv
module subsetFilter
  import subset_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] itemVal,
  input  logic [DATA_W-1:0] lowBound,
  input  logic [DATA_W-1:0] highBound,
  input  logic [1:0]        modeSel,
  output logic              admit
);

  always_comb begin
    unique case (filtMode_e'(modeSel))
      FILT_INCL:   admit = (itemVal >= lowBound) && (itemVal <= highBound);
      FILT_STRICT: admit = (itemVal > lowBound) && (itemVal < highBound);
      default:     admit = 1'b1;
    endcase
  end

endmodule

// File: rtl/subsetNet.sv
module subsetNet
  import subset_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHUNK_K = 4,
  parameter int TOP_N   = 2,
  parameter int BOT_N   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  netCtrl_t                ctl,
  input  logic [DATA_W-1:0]       inData,
  output logic                    anySwap,
  output logic [TOP_N*DATA_W-1:0] topData,
  output logic [TOP_N-1:0]        topValid,
  output logic [BOT_N*DATA_W-1:0] botData,
  output logic [BOT_N-1:0]        botValid
);

  localparam int NSLOT = TOP_N + CHUNK_K + BOT_N;
  localparam int MID0  = TOP_N;
  localparam int LOW0  = TOP_N + CHUNK_K;
  localparam int PTRW  = $clog2(CHUNK_K + 1);

  // Slot storage: index 0 is the top (largest) end
  logic [DATA_W-1:0] slotDat [NSLOT];
  logic [NSLOT-1:0]  slotOk;
  logic [PTRW-1:0]   fillPtr;

  // One compare-exchange element per adjacent pair
  logic [NSLOT-2:0] swp;

  for (genvar p = 0; p < NSLOT - 1; p++) begin : gCmp
    localparam bit ODDPAIR = (p % 2) == 1;
    localparam bit EDGEPAIR = (p == MID0 - 1) || (p == LOW0 - 1);
    logic outOfOrder;
    assign outOfOrder = (!slotOk[p] && slotOk[p+1]) ||
                        (slotOk[p] && slotOk[p+1] && (slotDat[p] < slotDat[p+1]));
    assign swp[p] = ctl.sortEn && (ctl.oddPhase == ODDPAIR) &&
                    !(EDGEPAIR && ctl.firstChunk) && outOfOrder;
  end

  assign anySwap = |swp;

  // Network after one phase
  logic [DATA_W-1:0] phDat [NSLOT];
  logic [NSLOT-1:0]  phOk;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      phDat[i] = slotDat[i];
      phOk[i]  = slotOk[i];
    end
    for (int p = 0; p < NSLOT - 1; p++) begin
      if (swp[p]) begin
        phDat[p]   = slotDat[p+1];
        phOk[p]    = slotOk[p+1];
        phDat[p+1] = slotDat[p];
        phOk[p+1]  = slotOk[p];
      end
    end
  end

  // Realignment: upper part from the sorted list head (first chunk only
  // moves anything), lower part from the window ending at the last valid
  // item, middle part emptied.
  logic [DATA_W-1:0] alDat [NSLOT];
  logic [NSLOT-1:0]  alOk;

  always_comb begin
    int nValid;
    int base;
    int winStart;
    int src;
    nValid   = $countones(slotOk);
    base     = ctl.firstChunk ? MID0 : 0;
    winStart = (nValid - BOT_N > TOP_N) ? (nValid - BOT_N) : TOP_N;
    for (int i = 0; i < NSLOT; i++) begin
      alDat[i] = slotDat[i];
      alOk[i]  = slotOk[i];
    end
    for (int i = 0; i < TOP_N; i++) begin
      src = base + i;
      if (src < NSLOT) begin
        alDat[i] = slotDat[src];
        alOk[i]  = slotOk[src];
      end else begin
        alOk[i] = 1'b0;
      end
    end
    for (int m = 0; m < CHUNK_K; m++) begin
      alOk[MID0+m] = 1'b0;
    end
    for (int j = 0; j < BOT_N; j++) begin
      src = base + winStart + j;
      if ((winStart + j < nValid) && (src < NSLOT)) begin
        alDat[LOW0+j] = slotDat[src];
        alOk[LOW0+j]  = slotOk[src];
      end else begin
        alOk[LOW0+j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) slotDat[i] <= '0;
      slotOk  <= '0;
      fillPtr <= '0;
    end else if (ctl.realign) begin
      for (int i = 0; i < NSLOT; i++) slotDat[i] <= alDat[i];
      slotOk  <= alOk;
      fillPtr <= '0;
    end else if (ctl.sortEn) begin
      for (int i = 0; i < NSLOT; i++) slotDat[i] <= phDat[i];
      slotOk <= phOk;
    end else if (ctl.loadWr) begin
      slotDat[MID0 + int'(fillPtr)] <= inData;
      slotOk[MID0 + int'(fillPtr)]  <= 1'b1;
      fillPtr <= fillPtr + PTRW'(1);
    end
  end

  for (genvar i = 0; i < TOP_N; i++) begin : gTopOut
    assign topData[i*DATA_W +: DATA_W] = slotDat[i];
    assign topValid[i]                 = slotOk[i];
  end

  for (genvar j = 0; j < BOT_N; j++) begin : gBotOut
    assign botData[j*DATA_W +: DATA_W] = slotDat[LOW0+j];
    assign botValid[j]                 = slotOk[LOW0+j];
  end

  // R6
  itemCount_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sortEn |=> $countones(slotOk) == $past($countones(slotOk)));

  // R7
  firstCut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sortEn && ctl.firstChunk) |=> $stable({topValid, topData, botValid, botData}));

  for (genvar i = 0; i + 1 < TOP_N; i++) begin : gTopChk
    // R3
    upperOrder_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctl.realign |=> (!slotOk[i+1] || (slotOk[i] && slotDat[i] >= slotDat[i+1])));
  end

  for (genvar j = 0; j + 1 < BOT_N; j++) begin : gBotChk
    // R4
    lowerOrder_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctl.realign |=> (!slotOk[LOW0+j+1] ||
                       (slotOk[LOW0+j] && slotDat[LOW0+j] >= slotDat[LOW0+j+1])));
  end

endmodule

// File: rtl/subsetCtrl.sv
module subsetCtrl
  import subset_pkg::*;
#(
  parameter int CHUNK_K = 4,
  parameter int NSLOT   = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     admit,
  input  logic     anySwap,
  output logic     inReady,
  output logic     done,
  output netCtrl_t ctl
);

  localparam int CNTW   = $clog2(CHUNK_K + 1);
  localparam int PHASEW = $clog2(NSLOT + 3) + 1;

  ctrlState_e        state;
  logic [CNTW-1:0]   arrCnt;
  logic              firstFlag;
  logic              lastSeen;
  logic              prevQuiet;
  logic              oddPh;
  logic [PHASEW-1:0] phaseCnt;
  logic              accept;
  logic              chunkEnd;

  assign inReady  = (state == ST_LOAD);
  assign done     = (state == ST_FIN);
  assign accept   = inValid && inReady;
  assign chunkEnd = accept && (inLast || (arrCnt == CNTW'(CHUNK_K - 1)));

  always_comb begin
    ctl.loadWr     = accept && admit;
    ctl.sortEn     = (state == ST_SORT);
    ctl.oddPhase   = oddPh;
    ctl.firstChunk = firstFlag;
    ctl.realign    = (state == ST_ALIGN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_LOAD;
      arrCnt    <= '0;
      firstFlag <= 1'b1;
      lastSeen  <= 1'b0;
      prevQuiet <= 1'b0;
      oddPh     <= 1'b0;
      phaseCnt  <= '0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (accept) begin
            if (chunkEnd) begin
              state     <= ST_SORT;
              arrCnt    <= '0;
              lastSeen  <= inLast;
              prevQuiet <= 1'b0;
              oddPh     <= 1'b0;
              phaseCnt  <= '0;
            end else begin
              arrCnt <= arrCnt + CNTW'(1);
            end
          end
        end
        ST_SORT: begin
          oddPh     <= !oddPh;
          prevQuiet <= !anySwap;
          phaseCnt  <= phaseCnt + PHASEW'(1);
          if (!anySwap && prevQuiet) state <= ST_ALIGN;
        end
        ST_ALIGN: begin
          firstFlag <= 1'b0;
          state     <= lastSeen ? ST_FIN : ST_LOAD;
        end
        default: state <= ST_FIN;
      endcase
    end
  end

  // R2
  chunkEnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    chunkEnd |=> !inReady);

  // R8
  sortLen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SORT) |-> (int'(phaseCnt) <= NSLOT + 1));

  // R9
  doneHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && !inReady));

endmodule

// File: rtl/subsetExtract.sv
module subsetExtract
  import subset_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHUNK_K = 4,
  parameter int TOP_N   = 2,
  parameter int BOT_N   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [DATA_W-1:0]       inData,
  input  logic                    inLast,
  input  logic [DATA_W-1:0]       boundLo,
  input  logic [DATA_W-1:0]       boundHi,
  input  logic [1:0]              filterMode,
  output logic [TOP_N*DATA_W-1:0] topData,
  output logic [TOP_N-1:0]        topValid,
  output logic [BOT_N*DATA_W-1:0] botData,
  output logic [BOT_N-1:0]        botValid,
  output logic                    done
);

  localparam int NSLOT = TOP_N + CHUNK_K + BOT_N;

  netCtrl_t ctl;
  logic     admit;
  logic     anySwap;

  subsetFilter #(.DATA_W(DATA_W)) i_filter (
    .itemVal  (inData),
    .lowBound (boundLo),
    .highBound(boundHi),
    .modeSel  (filterMode),
    .admit    (admit)
  );

  subsetCtrl #(.CHUNK_K(CHUNK_K), .NSLOT(NSLOT)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inLast (inLast),
    .admit  (admit),
    .anySwap(anySwap),
    .inReady(inReady),
    .done   (done),
    .ctl    (ctl)
  );

  subsetNet #(
    .DATA_W (DATA_W),
    .CHUNK_K(CHUNK_K),
    .TOP_N  (TOP_N),
    .BOT_N  (BOT_N)
  ) i_net (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inData  (inData),
    .anySwap (anySwap),
    .topData (topData),
    .topValid(topValid),
    .botData (botData),
    .botValid(botValid)
  );

endmodule

// File: tb/test_subsetExtract.sv
module test_subsetExtract;

  localparam int DATA_W  = 8;
  localparam int CHUNK_K = 4;
  localparam int TOP_N   = 2;
  localparam int BOT_N   = 2;
  localparam int MAXI    = 12;
  localparam int NVEC    = 8;

  typedef struct packed {
    logic [3:0]            cnt;
    logic [1:0]            mode;
    logic [7:0]            lo;
    logic [7:0]            hi;
    logic [0:MAXI-1][7:0]  items;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd10, 2'd0, 8'd0,  8'd255, {8'd50, 8'd3, 8'd77, 8'd12, 8'd9, 8'd200, 8'd45, 8'd1, 8'd130, 8'd60, 8'd0, 8'd0}},
    '{4'd8,  2'd1, 8'd10, 8'd100, {8'd5, 8'd10, 8'd100, 8'd101, 8'd50, 8'd99, 8'd11, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}},
    '{4'd8,  2'd2, 8'd10, 8'd100, {8'd5, 8'd10, 8'd100, 8'd101, 8'd50, 8'd99, 8'd11, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}},
    '{4'd1,  2'd0, 8'd0,  8'd0,   {8'd42, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}},
    '{4'd6,  2'd3, 8'd0,  8'd0,   {8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}},
    '{4'd12, 2'd0, 8'd0,  8'd0,   {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9, 8'd10, 8'd11, 8'd12}},
    '{4'd3,  2'd1, 8'd100, 8'd200,{8'd1, 8'd2, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}},
    '{4'd8,  2'd0, 8'd0,  8'd0,   {8'd240, 8'd230, 8'd220, 8'd210, 8'd200, 8'd190, 8'd180, 8'd170, 8'd0, 8'd0, 8'd0, 8'd0}}
  };

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    inValid = 1'b0;
  logic                    inReady;
  logic [DATA_W-1:0]       inData = '0;
  logic                    inLast = 1'b0;
  logic [DATA_W-1:0]       boundLo = '0;
  logic [DATA_W-1:0]       boundHi = '0;
  logic [1:0]              filterMode = 2'd0;
  logic [TOP_N*DATA_W-1:0] topData;
  logic [TOP_N-1:0]        topValid;
  logic [BOT_N*DATA_W-1:0] botData;
  logic [BOT_N-1:0]        botValid;
  logic                    done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  subsetExtract #(
    .DATA_W(DATA_W), .CHUNK_K(CHUNK_K), .TOP_N(TOP_N), .BOT_N(BOT_N)
  ) i_subsetExtract (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .boundLo(boundLo), .boundHi(boundHi),
    .filterMode(filterMode), .topData(topData), .topValid(topValid),
    .botData(botData), .botValid(botValid), .done(done)
  );

  task automatic chk(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance
  task automatic sendItem(input logic [7:0] d, input logic last);
    inValid = 1'b1;
    inData  = d;
    inLast  = last;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int guard = 0;
    while (!done && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " done raised"}, int'(done), 1);
  endtask

  // Model of R3/R4 from the admitted list
  task automatic checkSubsets(input string tag, input int adm[MAXI], input int v);
    int s[MAXI];
    int tmp;
    int winStart;
    for (int i = 0; i < MAXI; i++) s[i] = adm[i];
    for (int i = 0; i < v; i++)
      for (int k = i + 1; k < v; k++)
        if (s[k] > s[i]) begin tmp = s[i]; s[i] = s[k]; s[k] = tmp; end
    for (int i = 0; i < TOP_N; i++) begin
      chk($sformatf("R3 %s top%0d valid", tag, i), int'(topValid[i]), (i < v) ? 1 : 0);
      if (i < v)
        chk($sformatf("R3 %s top%0d data", tag, i), int'(topData[i*DATA_W +: DATA_W]), s[i]);
    end
    winStart = (v - BOT_N > TOP_N) ? v - BOT_N : TOP_N;
    for (int j = 0; j < BOT_N; j++) begin
      chk($sformatf("R4 %s bot%0d valid", tag, j), int'(botValid[j]), (winStart + j < v) ? 1 : 0);
      if (winStart + j < v)
        chk($sformatf("R4 %s bot%0d data", tag, j), int'(botData[j*DATA_W +: DATA_W]), s[winStart + j]);
    end
  endtask

  function automatic bit admitModel(input int d, input int mode, input int lo, input int hi);
    if (mode == 1) return (d >= lo) && (d <= hi);
    if (mode == 2) return (d > lo) && (d < hi);
    return 1'b1;
  endfunction

  function automatic string vecTag(input int n);
    case (n)
      0, 5, 7: return $sformatf("R7 vec%0d", n);
      1, 2:    return $sformatf("R5 vec%0d", n);
      6:       return $sformatf("R6 vec%0d", n);
      default: return $sformatf("R2 vec%0d", n);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int adm[MAXI];
    int v;
    int lowCnt;

    // R1: reset state
    doReset();
    chk("R1 done after reset", int'(done), 0);
    chk("R1 topValid after reset", int'(topValid), 0);
    chk("R1 botValid after reset", int'(botValid), 0);
    chk("R1 inReady after reset", int'(inReady), 1);

    // Table of streams
    for (int n = 0; n < NVEC; n++) begin
      doReset();
      filterMode = VECS[n].mode;
      boundLo    = VECS[n].lo;
      boundHi    = VECS[n].hi;
      v = 0;
      for (int i = 0; i < MAXI; i++) adm[i] = 0;
      for (int i = 0; i < int'(VECS[n].cnt); i++) begin
        sendItem(VECS[n].items[i], (i == int'(VECS[n].cnt) - 1));
        if (admitModel(int'(VECS[n].items[i]), int'(VECS[n].mode),
                       int'(VECS[n].lo), int'(VECS[n].hi))) begin
          adm[v] = int'(VECS[n].items[i]);
          v++;
        end
      end
      waitDone(vecTag(n));
      checkSubsets(vecTag(n), adm, v);
    end

    // R2/R8: ready timing of a descending first chunk, then R9 hold
    doReset();
    filterMode = 2'd0;
    sendItem(8'd9, 1'b0);
    sendItem(8'd8, 1'b0);
    sendItem(8'd7, 1'b0);
    chk("R2 ready open inside chunk", int'(inReady), 1);
    sendItem(8'd6, 1'b0);
    chk("R2 ready low after chunk close", int'(inReady), 0);
    lowCnt = 0;
    while (!inReady && lowCnt < 100) begin
      lowCnt++;
      @(negedge clk);
    end
    chk("R8 low cycles for sorted chunk", lowCnt, 3);
    chk("R7 first chunk top0 after copy", int'(topData[0 +: DATA_W]), 9);
    chk("R7 first chunk top1 after copy", int'(topData[DATA_W +: DATA_W]), 8);
    sendItem(8'd5, 1'b1);
    chk("R2 ready low after last item", int'(inReady), 0);
    waitDone("R9 directed");
    for (int i = 0; i < MAXI; i++) adm[i] = 0;
    adm[0] = 9; adm[1] = 8; adm[2] = 7; adm[3] = 6; adm[4] = 5;
    checkSubsets("R8 directed", adm, 5);
    repeat (6) @(negedge clk);
    chk("R9 done held", int'(done), 1);
    chk("R9 ready held low", int'(inReady), 0);

    // R6: offered items after done change nothing
    inValid = 1'b1;
    inData  = 8'd255;
    repeat (4) @(negedge clk);
    inValid = 1'b0;
    checkSubsets("R6 after done", adm, 5);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule